// File: doc/BRIEF.md
# Oversampling UART receiver

This block receives asynchronous serial bytes on a single input line. It has no receive FIFO. The line first passes through a synchronizer. A falling edge then starts a frame. Each bit period is timed as 16 oversample ticks, and the ticks come from an external tick input that a baud generator elsewhere in the chip provides.

Each bit value is taken at sub-sample index 7, counted from the detected start edge. The receiver collects eight data bits, least significant bit first, and then checks the stop bit. The finished byte goes into one holding register and is announced by a single-cycle valid strobe. A framing-error flag and an overrun flag go with it. Software or a DMA engine takes the byte and acknowledges the read with a one-cycle read pulse.

Top module: `uart_os_rx`

## Requirements
- R1: While the line stays high, no frame starts and `valid_o` stays low. A high-to-low transition of the synchronized line starts a frame.
- R2: A frame is a low start bit, then eight data bits with bit 0 first, then a stop bit. `data_o` bit n holds the n-th data bit received.
- R3: Every bit is sampled once, on the oversample tick with index 7 of 0..15, counted from the start detection. Line values outside the middle of a bit period have no effect on the received byte.
- R4: `valid_o` is high for exactly one clock per received frame. `data_o` changes only in that cycle.
- R5: A low stop bit sets `frame_err_o` in the cycle `valid_o` is high, and the byte is still delivered. A later frame with a high stop bit clears `frame_err_o`.
- R6: If the start bit reads high at its sample point, the frame is dropped and no `valid_o` pulse follows.
- R7: `overrun_o` goes high when a byte completes while the previous byte has not been acknowledged by `rd_i`. A pulse on `rd_i` clears it in the next cycle.
- R8: After the stop-bit sample the receiver looks for a new start edge at once. A frame whose start edge comes 11 ticks into the previous stop bit is received correctly.
- R9: After reset, `data_o` is 0 and `valid_o`, `frame_err_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | One-cycle pulse, 16 per bit period |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| rd_i | input | 1 | Read acknowledge for the holding register |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle strobe for a new byte |
| frame_err_o | output | 1 | Stop bit of the last byte was low |
| overrun_o | output | 1 | A byte completed before the previous one was read |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, sample index 7, eight data bits and a two-stage synchronizer. It pulses the tick on every third clock, so each bit lasts 48 clocks. At that resolution the bench can corrupt the outer ticks of every bit, cut a stop bit short so the next start edge comes 11 ticks in, and send a start glitch that ends before the sample point. This makes the sample window, the early re-arm and the false-start path directly observable.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic level_o,
  output logic fall_o
);
  // stages 0..SYNC_STAGES-1 synchronize, the last stage holds the previous level
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], rxd_i};
  end

  assign level_o = pipe_q[SYNC_STAGES-1];
  assign fall_o  = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_os_rx_core.sv
module uart_os_rx_core
  import uart_os_rx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned SAMPLE_IDX = 7,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              fall_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned TCNT_W = $clog2(OSR);
  localparam int unsigned BCNT_W = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              at_sample, at_end;

  assign at_sample = tick_i && (tcnt_q == TCNT_W'(SAMPLE_IDX));
  assign at_end    = tick_i && (tcnt_q == TCNT_W'(OSR - 1));
  assign byte_o    = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      tcnt_q    <= '0;
      bcnt_q    <= '0;
      shreg_q   <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (fall_i) begin
          state_q <= RX_START;
          tcnt_q  <= '0;
          bcnt_q  <= '0;
        end
      end else if (tick_i) begin
        tcnt_q <= at_end ? '0 : tcnt_q + 1'b1;
        if (at_sample) begin
          unique case (state_q)
            RX_START: if (rx_i) state_q <= RX_IDLE;  // false start
            RX_DATA: begin
              shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
              bcnt_q  <= bcnt_q + 1'b1;
            end
            RX_STOP: begin
              done_o    <= 1'b1;
              stop_ok_o <= rx_i;
              state_q   <= RX_IDLE;  // re-arm right after the stop sample
            end
            default: ;
          endcase
        end
        if (at_end) begin
          if (state_q == RX_START) state_q <= RX_DATA;
          else if (state_q == RX_DATA && bcnt_q == BCNT_W'(DATA_W)) state_q <= RX_STOP;
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
      full_q      <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (rd_i) begin
        full_q    <= 1'b0;
        overrun_o <= 1'b0;
      end
      if (done_i) begin
        data_o      <= byte_i;
        frame_err_o <= ~stop_ok_i;
        full_q      <= 1'b1;
        if (full_q && !rd_i) overrun_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SAMPLE_IDX  = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              rx_level, rx_fall, done, stop_ok;
  logic [DATA_W-1:0] rx_byte;

  uart_os_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .level_o(rx_level),
    .fall_o (rx_fall)
  );

  uart_os_rx_core #(.OSR(OSR), .SAMPLE_IDX(SAMPLE_IDX), .DATA_W(DATA_W)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (os_tick_i),
    .rx_i     (rx_level),
    .fall_i   (rx_fall),
    .done_o   (done),
    .stop_ok_o(stop_ok),
    .byte_o   (rx_byte)
  );

  uart_os_rx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .stop_ok_i  (stop_ok),
    .byte_i     (rx_byte),
    .rd_i       (rd_i),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .frame_err_o(frame_err_o),
    .overrun_o  (overrun_o)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              frame_err_o,
  input logic              overrun_o
);
  p_strobe_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_data_only_on_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  p_ferr_only_on_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_err_o) |-> valid_o);

  p_overrun_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> valid_o);

  p_overrun_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> !overrun_o);
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .frame_err_o(frame_err_o),
  .overrun_o  (overrun_o)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  localparam int TICK_DIV = 3;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, frame_err_o, overrun_o;

  int checks = 0, failures = 0;
  int n_valid = 0, n_wide = 0;
  logic [7:0] cap_data;
  logic       cap_ferr;

  uart_os_rx i_uart_os_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .os_tick_i(os_tick_i), .rxd_i(rxd_i), .rd_i(rd_i),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  always #2 clk_i = ~clk_i;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_i);
      os_tick_i = (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  initial begin
    logic prev = 1'b0;
    forever begin
      @(negedge clk_i);
      if (valid_o) begin
        n_valid++;
        cap_data = data_o;
        cap_ferr = frame_err_o;
        if (prev) n_wide++;
      end
      prev = valid_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int clks);
    rxd_i = v;
    repeat (clks) @(negedge clk_i);
  endtask

  task automatic drive_window_bit(input logic v);
    drive_bit(~v, BIT_CLKS / 4);
    drive_bit(v, BIT_CLKS / 2);
    drive_bit(~v, BIT_CLKS / 4);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int stop_ticks, input bit window);
    drive_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      if (window) drive_window_bit(b[i]);
      else        drive_bit(b[i], BIT_CLKS);
    end
    drive_bit(stop, stop_ticks * TICK_DIV);
    rxd_i = 1'b1;
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(data_o == 8'h00, "R9 data", data_o, 0);
    chk(!valid_o && !frame_err_o && !overrun_o, "R9 flags",
        {valid_o, frame_err_o, overrun_o}, 0);
  endtask

  task automatic t_idle();
    int n0 = n_valid;
    repeat (4 * BIT_CLKS) @(negedge clk_i);
    chk(n_valid == n0, "R1 idle line", n_valid - n0, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] pat[4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    foreach (pat[k]) begin
      int n0 = n_valid;
      do_read();
      send(pat[k], 1'b1, 16, 1'b0);
      drive_bit(1'b1, BIT_CLKS);
      chk(n_valid == n0 + 1, "R4 one strobe", n_valid - n0, 1);
      chk(cap_data == pat[k], "R2 byte", cap_data, pat[k]);
      chk(!cap_ferr, "R5 no ferr", cap_ferr, 0);
    end
    chk(n_wide == 0, "R4 strobe width", n_wide, 0);
  endtask

  task automatic t_window();
    do_read();
    send(8'h96, 1'b1, 16, 1'b1);
    drive_bit(1'b1, BIT_CLKS);
    chk(cap_data == 8'h96, "R3 mid-bit sample", cap_data, 8'h96);
    do_read();
    send(8'h4B, 1'b1, 16, 1'b1);
    drive_bit(1'b1, BIT_CLKS);
    chk(cap_data == 8'h4B, "R3 mid-bit sample", cap_data, 8'h4B);
  endtask

  task automatic t_frame_err();
    do_read();
    send(8'h81, 1'b0, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(cap_ferr, "R5 ferr on strobe", cap_ferr, 1);
    chk(cap_data == 8'h81, "R5 byte kept", cap_data, 8'h81);
    chk(frame_err_o, "R5 ferr held", frame_err_o, 1);
    do_read();
    send(8'h18, 1'b1, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(!frame_err_o, "R5 ferr cleared", frame_err_o, 0);
  endtask

  task automatic t_false_start();
    int n0;
    do_read();
    n0 = n_valid;
    drive_bit(1'b0, 2 * TICK_DIV);
    drive_bit(1'b1, 12 * BIT_CLKS);
    chk(n_valid == n0, "R6 false start dropped", n_valid - n0, 0);
    send(8'h66, 1'b1, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(n_valid == n0 + 1 && cap_data == 8'h66, "R6 recovers", cap_data, 8'h66);
  endtask

  task automatic t_overrun();
    do_read();
    send(8'h11, 1'b1, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(!overrun_o, "R7 no overrun", overrun_o, 0);
    send(8'h22, 1'b1, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(overrun_o, "R7 overrun set", overrun_o, 1);
    chk(data_o == 8'h22, "R7 newest byte", data_o, 8'h22);
    do_read();
    chk(!overrun_o, "R7 read clears", overrun_o, 0);
  endtask

  task automatic t_rearm();
    int n0;
    do_read();
    n0 = n_valid;
    send(8'h5A, 1'b1, 11, 1'b0);
    chk(n_valid == n0 + 1 && cap_data == 8'h5A, "R8 first frame", cap_data, 8'h5A);
    do_read();
    send(8'hC3, 1'b1, 16, 1'b0);
    drive_bit(1'b1, BIT_CLKS);
    chk(n_valid == n0 + 2, "R8 both frames", n_valid - n0, 2);
    chk(cap_data == 8'hC3, "R8 second byte", cap_data, 8'hC3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    t_idle();
    t_bytes();
    t_window();
    t_frame_err();
    t_false_start();
    t_overrun();
    t_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule